// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a watchdog that software must service at regular intervals. One 8-bit control register, reached over a simple single-cycle register bus, turns the watchdog on and chooses the time base and the time-out length. It also chooses what an expiry does: raise a reset request or raise a non-maskable interrupt. Two status bits in the same register record which of the two events last fired. Software polls them, and reading the register clears them.

Three time bases can drive the counter, and all of them arrive as strobes in the system clock domain. The first is the system clock itself, which counts on every cycle. The second is a 32.768 kHz real-time strobe and the third is a strobe from an on-chip RC oscillator of about 10 kHz. The terminal count depends on both the time base and the 2-bit period code. Software restarts the count by writing a fixed two-byte key sequence to a separate key register. Changing the time base or the period also restarts the count.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x04. Bit 0 is the enable and reads 0. Bits 2:1 are the time base and read 10 (RC). Bits 4:3 are the period and read 00. Bit 5 is the action and reads 0 (reset request). Bit 6 is the reset flag and bit 7 is the NMI flag, and both read 0. Both event outputs are low.
- R2: The counter expires after 2^E counted ticks. The time base (bits 2:1) and the period code (bits 4:3) select E. For the system clock (00), codes 00/01/10/11 give E = 27/25/22/18, each reduced by the parameter SYS_TRIM. For the real-time strobe (01) they give 17/14/11/7. For the RC strobe (10) they give 15/13/9/5.
- R3: While enabled, the counter advances only on the strobe of the selected time base, and every cycle counts for the system clock. With the reserved time base 11 selected, the counter does not advance and never expires.
- R4: When the action bit is 0, expiry drives rst_req_o high for exactly one cycle and sets the reset flag (bit 6). The pulse is visible in the cycle that follows the clock edge which counted the final tick.
- R5: When the action bit is 1, expiry drives nmi_o high for exactly one cycle and sets the NMI flag (bit 7). rst_req_o stays low.
- R6: A read of the control register returns the flags and then clears both of them. If an expiry falls in the same cycle, setting the flag wins over clearing it.
- R7: Writing 0xA5 and then 0x5A to the key register, with no other key write between them, restarts the count from zero at the second write. Any other key byte breaks the sequence, and a lone 0x5A has no effect.
- R8: A control write that changes the time base or the period restarts the count. A control write that leaves both unchanged does not touch the count.
- R9: After an expiry the counter restarts from zero, so expiries repeat every 2^E ticks.
- R10: While the enable bit is 0, the counter is held at zero and neither output pulses. Re-enabling starts a full period.
- R11: Control writes cannot change bits 7:6. The flags change only through expiry and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Register address (control at CTL_ADDR, key at KEY_ADDR) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (a control read clears the flags) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data; the control register when the address matches it, otherwise zero |
| rtc_tick_i | input | 1 | Real-time clock strobe, one system cycle wide |
| rc_tick_i | input | 1 | RC oscillator strobe, one system cycle wide |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| nmi_o | output | 1 | One-cycle non-maskable interrupt on expiry |

## Verification
A control write or a completed key sequence takes effect at the edge that samples it, so the ticks counted towards expiry are the selected strobes seen at the following edges. The event pulse and its flag appear together, one register stage after the edge that counted the 2^E-th tick. Read data is combinational, so it is taken during the read cycle, and the clearing of the flags shows on the next read. The bench drives strobes on falling edges and counts the strobes it offered at each rising edge. It then checks at the next falling edge that the pulse appears exactly at its own tick count and at no earlier cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      SRC_SYS = 2'b00,
      SRC_RTC = 2'b01,
      SRC_RC  = 2'b10,
      SRC_RSV = 2'b11
   } wdt_src_e;

   // Packed layout, bit 0 first: en, src[2:1], per[4:3], act[5], rflag[6], nflag[7]
   typedef struct packed {
      logic       nmi_flag;
      logic       rst_flag;
      logic       act_nmi;
      logic [1:0] per;
      wdt_src_e   src;
      logic       en;
   } wdt_ctl_t;

   localparam wdt_ctl_t CTL_RESET = '{
      nmi_flag: 1'b0, rst_flag: 1'b0, act_nmi: 1'b0,
      per: 2'b00, src: SRC_RC, en: 1'b0 };

   localparam logic [7:0] KEY_ARM  = 8'hA5;
   localparam logic [7:0] KEY_FIRE = 8'h5A;

   localparam int unsigned SYS_TOP_EXP = 27;
   localparam int unsigned SLOW_TOP_EXP = 17;

   // Exponent of the tick count for a time base and period code
   function automatic int unsigned tmo_exp(input int unsigned src,
                                           input int unsigned per,
                                           input int unsigned sys_trim);
      int unsigned e;
      e = 1;
      case (src)
         0: case (per)
               0: e = 27 - sys_trim;
               1: e = 25 - sys_trim;
               2: e = 22 - sys_trim;
               default: e = 18 - sys_trim;
            endcase
         1: case (per)
               0: e = 17;
               1: e = 14;
               2: e = 11;
               default: e = 7;
            endcase
         2: case (per)
               0: e = 15;
               1: e = 13;
               2: e = 9;
               default: e = 5;
            endcase
         default: e = 1;
      endcase
      return e;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned sys_trim);
      int unsigned s;
      s = SYS_TOP_EXP - sys_trim;
      return (s > SLOW_TOP_EXP) ? s : SLOW_TOP_EXP;
   endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
   import wdt_pkg::*;
(
   input  wdt_src_e src_i,
   input  logic     rtc_tick_i,
   input  logic     rc_tick_i,
   output logic     tick_o,
   output logic     valid_o
);

   logic [3:0] strobes;

   always_comb begin
      strobes[SRC_SYS] = 1'b1;
      strobes[SRC_RTC] = rtc_tick_i;
      strobes[SRC_RC]  = rc_tick_i;
      strobes[SRC_RSV] = 1'b0;
      tick_o  = strobes[src_i];
      valid_o = (src_i != SRC_RSV);
   end

endmodule

// File: rtl/wdt_limit.sv
module wdt_limit
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 27,
   parameter int unsigned SYS_TRIM = 0
)(
   input  wdt_src_e         src_i,
   input  logic [1:0]       per_i,
   output logic [CNT_W-1:0] term_o
);

   localparam int unsigned N_SRC = 4;
   localparam int unsigned N_PER = 4;

   logic [CNT_W-1:0] tab [N_SRC*N_PER];

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      for (genvar p = 0; p < N_PER; p++) begin : g_per
         if (s == N_SRC - 1) begin : g_rsv
            assign tab[s*N_PER+p] = '0;
         end else begin : g_live
            localparam int unsigned E = tmo_exp(s, p, SYS_TRIM);
            assign tab[s*N_PER+p] = CNT_W'((64'd1 << E) - 64'd1);
         end
      end
   end

   assign term_o = tab[{src_i, per_i}];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 27
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] term_i,
   output logic             expire_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             step;
   logic             hit;

   always_comb begin
      step     = run_i & tick_i;
      hit      = step & (cnt_q == term_i);
      expire_o = hit & ~clr_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i || hit) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   output logic       refresh_o
);

   logic armed_q;

   assign refresh_o = wr_i & armed_q & (wdata_i == KEY_FIRE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
      end else if (wr_i) begin
         armed_q <= (wdata_i == KEY_ARM);
      end
   end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned CTL_ADDR = 0,
   parameter int unsigned KEY_ADDR = 1,
   parameter int unsigned SYS_TRIM = 0
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   input  logic              rtc_tick_i,
   input  logic              rc_tick_i,
   output logic              rst_req_o,
   output logic              nmi_o
);

   localparam int unsigned CNT_W = cnt_width(SYS_TRIM);

   if (SYS_TRIM > 17) begin : g_bad_trim
      $error("SYS_TRIM must leave a system exponent of at least 1");
   end
   if (CTL_ADDR == KEY_ADDR) begin : g_bad_map
      $error("control and key registers need distinct addresses");
   end
   if ((CTL_ADDR >> ADDR_W) != 0 || (KEY_ADDR >> ADDR_W) != 0) begin : g_bad_addr
      $error("register address does not fit ADDR_W");
   end

   wdt_ctl_t         ctl_q;
   wdt_ctl_t         ctl_wr;
   logic             sel_ctl, sel_key;
   logic             wr_ctl, rd_ctl, wr_key;
   logic             cfg_change;
   logic             refresh;
   logic             cnt_clr;
   logic             tick, src_valid, run;
   logic             expire;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt_q;
   logic             rst_req_q, nmi_q;

   always_comb begin
      sel_ctl = (bus_addr_i == ADDR_W'(CTL_ADDR));
      sel_key = (bus_addr_i == ADDR_W'(KEY_ADDR));
      wr_ctl  = bus_wr_i & sel_ctl;
      rd_ctl  = bus_rd_i & sel_ctl;
      wr_key  = bus_wr_i & sel_key;

      ctl_wr          = wdt_ctl_t'(bus_wdata_i);
      ctl_wr.rst_flag = ctl_q.rst_flag;
      ctl_wr.nmi_flag = ctl_q.nmi_flag;

      cfg_change = wr_ctl & ((ctl_wr.src != ctl_q.src) || (ctl_wr.per != ctl_q.per));
      cnt_clr    = refresh | cfg_change | ~ctl_q.en;
      run        = ctl_q.en & src_valid;
   end

   wdt_key_seq u_key (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_key),
      .wdata_i   (bus_wdata_i),
      .refresh_o (refresh)
   );

   wdt_tick_sel u_tick (
      .src_i      (ctl_q.src),
      .rtc_tick_i (rtc_tick_i),
      .rc_tick_i  (rc_tick_i),
      .tick_o     (tick),
      .valid_o    (src_valid)
   );

   wdt_limit #(
      .CNT_W    (CNT_W),
      .SYS_TRIM (SYS_TRIM)
   ) u_limit (
      .src_i  (ctl_q.src),
      .per_i  (ctl_q.per),
      .term_o (term)
   );

   wdt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (cnt_clr),
      .run_i    (run),
      .tick_i   (tick),
      .term_i   (term),
      .expire_o (expire),
      .cnt_o    (cnt_q)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctl_q     <= CTL_RESET;
         rst_req_q <= 1'b0;
         nmi_q     <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctl_q.en      <= ctl_wr.en;
            ctl_q.src     <= ctl_wr.src;
            ctl_q.per     <= ctl_wr.per;
            ctl_q.act_nmi <= ctl_wr.act_nmi;
         end
         ctl_q.rst_flag <= (expire & ~ctl_q.act_nmi) | (ctl_q.rst_flag & ~rd_ctl);
         ctl_q.nmi_flag <= (expire &  ctl_q.act_nmi) | (ctl_q.nmi_flag & ~rd_ctl);
         rst_req_q      <= expire & ~ctl_q.act_nmi;
         nmi_q          <= expire &  ctl_q.act_nmi;
      end
   end

   assign bus_rdata_o = sel_ctl ? ctl_q : 8'h00;
   assign rst_req_o   = rst_req_q;
   assign nmi_o       = nmi_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W = 27
)(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rst_req_o,
   input logic             nmi_o,
   input wdt_ctl_t         ctl,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] term,
   input logic             cnt_clr
);

   a_r4_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rst_req_o && nmi_o));

   a_r4_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o);

   a_r5_nmi_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_o |=> !nmi_o);

   a_r4_rst_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> ctl.rst_flag);

   a_r5_nmi_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_o |-> (ctl.nmi_flag && $past(ctl.act_nmi)));

   a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_req_o || nmi_o) |-> (cnt == '0));

   a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl.src != SRC_RSV) |-> (cnt <= term));

   a_r3_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl.src == SRC_RSV && !cnt_clr) |=> $stable(cnt));

   a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl.en |=> (cnt == '0));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .rst_req_o (rst_req_o),
   .nmi_o     (nmi_o),
   .ctl       (ctl_q),
   .cnt       (cnt_q),
   .term      (term),
   .cnt_clr   (cnt_clr)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

   localparam int unsigned TRIM     = 13;
   localparam int unsigned WD_LIMIT = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rtc_tick = 1'b0;
   logic       rc_tick = 1'b0;
   logic       rst_req;
   logic       nmi;

   int unsigned n_run = 0;
   int unsigned n_fail = 0;
   int unsigned cyc = 0;

   always #10 clk = ~clk;

   wdog_timer #(
      .ADDR_W (2), .CTL_ADDR (0), .KEY_ADDR (1), .SYS_TRIM (TRIM)
   ) u_wdog_timer (
      .clk_i (clk), .rst_ni (rst_n), .bus_addr_i (addr), .bus_wr_i (wr),
      .bus_rd_i (rd), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
      .rtc_tick_i (rtc_tick), .rc_tick_i (rc_tick),
      .rst_req_o (rst_req), .nmi_o (nmi)
   );

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         n_run  = n_run + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles, expected below %0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   function automatic int unsigned exp_of(input int unsigned src, input int unsigned per);
      int unsigned sys_e [4] = '{27, 25, 22, 18};
      int unsigned rtc_e [4] = '{17, 14, 11, 7};
      int unsigned rc_e  [4] = '{15, 13, 9, 5};
      if (src == 0) return sys_e[per] - TRIM;
      if (src == 1) return rtc_e[per];
      return rc_e[per];
   endfunction

   function automatic logic [7:0] cfg(input bit en, input int unsigned src,
                                      input int unsigned per, input bit act);
      return {2'b00, act, per[1:0], src[1:0], en};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_run = n_run + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // All bus tasks start and end at a falling edge.
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(output logic [7:0] d);
      addr = 2'd0; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic refresh();
      bus_write(2'd1, 8'hA5);
      bus_write(2'd1, 8'h5A);
   endtask

   // Offer k cycles with every strobe high; no event may appear.
   task automatic run_ticks(input int unsigned k, input string req);
      int unsigned bad = 0;
      for (int i = 0; i < k; i++) begin
         rtc_tick = 1'b1; rc_tick = 1'b1;
         @(negedge clk);
         if (rst_req || nmi) bad++;
      end
      rtc_tick = 1'b0; rc_tick = 1'b0;
      check(bad == 0, req, bad, 0);
   endtask

   // Count selected strobes until n; the event must appear exactly then.
   task automatic run_expect(input int unsigned n, input int unsigned src,
                             input bit act, input int unsigned pct, input string req);
      int unsigned seen = 0;
      int unsigned at = 0;
      int unsigned steps = 0;
      bit          early = 1'b0;
      bit          t_rtc, t_rc, counted;
      while (at == 0 && !early) begin
         t_rtc = ($urandom_range(99) < pct);
         t_rc  = ($urandom_range(99) < pct);
         rtc_tick = t_rtc; rc_tick = t_rc;
         @(negedge clk);
         steps++;
         counted = (src == 0) ? 1'b1 : ((src == 1) ? t_rtc : t_rc);
         if (counted) seen++;
         if (counted && seen == n) begin
            at = steps;
            if (!(act ? (nmi && !rst_req) : (rst_req && !nmi))) early = 1'b1;
         end else if (rst_req || nmi) begin
            early = 1'b1;
         end
      end
      rtc_tick = 1'b0; rc_tick = 1'b0;
      check(!early, req, seen, n);
   endtask

   initial begin
      logic [7:0] d;
      int unsigned srcs [11] = '{0, 0, 0, 0, 1, 1, 1, 2, 2, 2, 2};
      int unsigned pers [11] = '{3, 2, 1, 0, 3, 2, 1, 3, 2, 1, 0};
      int unsigned pcts [11] = '{100, 100, 100, 100, 50, 100, 100, 40, 60, 100, 100};
      bit act;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check(!rst_req && !nmi, "R1 outputs", {rst_req, nmi}, 0);
      bus_read(d);
      check(d == 8'h04, "R1 control reset value", d, 8'h04);

      // R11: flag bits not writable
      bus_write(2'd0, 8'hC4);
      bus_read(d);
      check(d == 8'h04, "R11 flags read-only", d, 8'h04);

      // R10: disabled, strobes running, no events
      run_ticks(100, "R10 disabled quiet");

      // R2/R4/R5/R6: table sweep across time bases and periods
      for (int i = 0; i < 11; i++) begin
         act = $urandom_range(1);
         bus_write(2'd0, cfg(1'b1, srcs[i], pers[i], act));
         refresh();
         run_expect(1 << exp_of(srcs[i], pers[i]), srcs[i], act, pcts[i],
                    act ? "R2 R5 nmi expiry" : "R2 R4 reset expiry");
         bus_read(d);
         check(d[7:6] == {act, ~act}, "R6 flag readable", d[7:6], {act, ~act});
         bus_read(d);
         check(d[7:6] == 2'b00, "R6 flags cleared by read", d[7:6], 0);
      end

      // R9: periodic restart
      bus_write(2'd0, cfg(1'b1, 2, 3, 1'b0));
      refresh();
      run_expect(32, 2, 1'b0, 100, "R9 first period");
      run_expect(32, 2, 1'b0, 100, "R9 second period");
      run_expect(32, 2, 1'b0, 70, "R9 third period");

      // R7: key sequence
      run_ticks(20, "R7 partial count");
      refresh();
      run_expect(32, 2, 1'b0, 100, "R7 key restarts count");
      run_ticks(20, "R7 partial count");
      bus_write(2'd1, 8'hA5);
      bus_write(2'd1, 8'h33);
      run_expect(12, 2, 1'b0, 100, "R7 broken sequence ignored");
      run_ticks(10, "R7 partial count");
      bus_write(2'd1, 8'h5A);
      run_expect(22, 2, 1'b0, 100, "R7 lone second byte ignored");

      // R8: config writes
      run_ticks(20, "R8 partial count");
      bus_write(2'd0, cfg(1'b1, 2, 3, 1'b0));
      run_expect(12, 2, 1'b0, 100, "R8 same config keeps count");
      run_ticks(5, "R8 partial count");
      bus_write(2'd0, cfg(1'b1, 2, 2, 1'b0));
      run_expect(512, 2, 1'b0, 100, "R8 period change restarts");
      bus_write(2'd0, cfg(1'b1, 2, 3, 1'b1));
      run_ticks(5, "R8 partial count");
      bus_write(2'd0, cfg(1'b1, 1, 3, 1'b1));
      run_expect(128, 1, 1'b1, 100, "R8 source change restarts");

      // R3: reserved time base never expires
      bus_write(2'd0, cfg(1'b1, 3, 3, 1'b0));
      run_ticks(300, "R3 reserved source stalls");

      // R10: disable mid-count clears the count
      bus_write(2'd0, cfg(1'b1, 2, 3, 1'b0));
      run_ticks(20, "R10 partial count");
      bus_write(2'd0, cfg(1'b0, 2, 3, 1'b0));
      run_ticks(50, "R10 disabled quiet");
      bus_write(2'd0, cfg(1'b1, 2, 3, 1'b0));
      run_expect(32, 2, 1'b0, 100, "R10 full period after re-enable");

      finish_run();
   end

endmodule